// File: doc/BRIEF.md
# Prescaled Bit-Toggle Interrupt Timer

This block is a 16-bit up-counter for a small microcontroller. It counts ticks from one of several clock sources, scaled by a selectable power-of-four ratio. It raises an interrupt request when one chosen upper counter bit changes in one chosen direction. The counter does not raise a request on wrap-around. Each on-chip clock source reaches the block as a one-cycle tick enable. Two external pins arrive as raw levels. The block synchronizes them and counts their rising edges.

Software controls the block through four write ports:

- a mode register that picks the source, the ratio and the watched bit;
- an edge register whose bit 4 picks the direction;
- a direct counter load;
- the shared request register. The block sets bit 2 of this register, and software clears that bit.

Oscillators, the interrupt controller and bus decode live outside the block.

Top module: `prescale_toggle_timer`

## Requirements
- R1: After reset, the counter, the prescaler, the mode register, the edge register and the request register all read zero, and source ticks do not change the counter.
- R2: Mode bits [7:5] pick the tick source: 1 system tick, 3 pin A, 4 fast RC tick, 5 crystal tick, 6 slow RC tick, 7 pin B. Codes 0 and 2 select no source. Ticks from sources that are not selected have no effect.
- R3: Mode bits [4:3] pick the prescale ratio: 0 gives 1, 1 gives 4, 2 gives 16, 3 gives 64. The counter increments by one each time that many selected ticks have arrived, and the prescaler then restarts from zero.
- R4: The counter wraps from 0xFFFF to 0x0000. A counter load takes any 16-bit value, takes priority over an increment in the same cycle, and never sets the request flag.
- R5: Mode bits [2:0] = n make counter bit n+8 the watched bit. A change of any other bit raises no request.
- R6: With edge-register bit 4 = 0, a 0-to-1 change of the watched bit caused by an increment raises a request. With bit 4 = 1, a 1-to-0 change raises one instead. Changes in the other direction raise nothing.
- R7: A request sets bit 2 of the request register and leaves its other bits unchanged. Software writes the whole register. When a request and a software write that clears bit 2 fall in the same cycle, bit 2 ends up set.
- R8: A mode write whose value differs from the current value clears the prescaler, and no count happens in that cycle. A mode write with the same value has no effect.
- R9: While no source is selected, the counter and the prescaler hold their values.
- R10: Each pin passes through two synchronizer flops. Each rising edge counts as exactly one tick, and a steady level adds nothing. With ratio 1, a pin raised before clock edge k shows in the counter after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_sys_i | input | 1 | System clock tick enable |
| tick_hrc_i | input | 1 | Fast RC oscillator tick enable |
| tick_xosc_i | input | 1 | Crystal oscillator tick enable |
| tick_lrc_i | input | 1 | Slow RC oscillator tick enable |
| pin_a_i | input | 1 | Raw external pin A level |
| pin_b_i | input | 1 | Raw external pin B level |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| edge_we_i | input | 1 | Edge register write strobe |
| edge_wdata_i | input | 8 | Edge register write data |
| cnt_we_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 16 | Counter load value |
| irq_we_i | input | 1 | Request register write strobe |
| irq_wdata_i | input | 8 | Request register write data |
| mode_o | output | 8 | Current mode register |
| edge_o | output | 8 | Current edge register |
| cnt_o | output | 16 | Current counter value |
| irq_o | output | 8 | Current request register |

## Verification
The hardest case to reach is the watched bit changing in the requested direction. With the ÷1 ratio, the upper bits would otherwise take hundreds of ticks to change. The stimulus therefore loads the counter one step below the transition, such as 0x00FF or 0x07FF, and then supplies one tick. The same load-then-tick approach reaches the wrap at 0xFFFF, the wrong-direction changes, and changes of bits that are not watched. Prescaler clearing is not visible at the ports, so it is checked indirectly. The bench leaves a partial remainder in the prescaler and rewrites the mode register. It then counts how many further ticks the first increment needs.

// File: rtl/ptim_pkg.sv
package ptim_pkg;
  typedef enum logic [2:0] {
    SRC_OFF0  = 3'd0,
    SRC_SYS   = 3'd1,
    SRC_OFF2  = 3'd2,
    SRC_PIN_A = 3'd3,
    SRC_HRC   = 3'd4,
    SRC_XOSC  = 3'd5,
    SRC_LRC   = 3'd6,
    SRC_PIN_B = 3'd7
  } src_sel_e;

  localparam int NUM_SRC  = 8;
  localparam int NUM_PINS = 2;
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R10: one tick per edge
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import ptim_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_sys_i,
  input  logic     tick_hrc_i,
  input  logic     tick_xosc_i,
  input  logic     tick_lrc_i,
  input  logic     pin_a_i,
  input  logic     pin_b_i,
  input  src_sel_e sel_i,
  output logic     tick_o
);
  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_rise;
  logic [NUM_SRC-1:0]  src_vec;

  assign pin_raw = {pin_b_i, pin_a_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_raw[g]),
      .rise_o (pin_rise[g])
    );
  end

  always_comb begin
    src_vec            = '0;
    src_vec[SRC_SYS]   = tick_sys_i;
    src_vec[SRC_PIN_A] = pin_rise[0];
    src_vec[SRC_HRC]   = tick_hrc_i;
    src_vec[SRC_XOSC]  = tick_xosc_i;
    src_vec[SRC_LRC]   = tick_lrc_i;
    src_vec[SRC_PIN_B] = pin_rise[1];
  end

  assign tick_o = src_vec[sel_i];
endmodule

// File: rtl/prescaler.sv
module prescaler #(
  parameter int PRE_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic [1:0] ratio_sel_i,
  output logic       carry_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_v;

  // ratio = 4**sel, terminal value = ratio-1
  assign last_v  = PRE_W'((32'd1 << (32'(ratio_sel_i) * 2)) - 32'd1);
  assign carry_o = tick_i & ~clr_i & (pre_q == last_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (carry_o) pre_q <= '0;
    else if (tick_i)  pre_q <= pre_q + 1'b1;
  end

  a_r3_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= last_v);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/prescale_toggle_timer.sv
module prescale_toggle_timer
  import ptim_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_BIT     = 2,
  parameter int EDGE_BIT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_sys_i,
  input  logic             tick_hrc_i,
  input  logic             tick_xosc_i,
  input  logic             tick_lrc_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             mode_we_i,
  input  logic [7:0]       mode_wdata_i,
  input  logic             edge_we_i,
  input  logic [7:0]       edge_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             irq_we_i,
  input  logic [7:0]       irq_wdata_i,
  output logic [7:0]       mode_o,
  output logic [7:0]       edge_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       irq_o
);
  localparam int IDX_W    = $clog2(CNT_W);
  localparam int SEL_BASE = CNT_W - 8;

  logic [7:0]       mode_q, edge_q, irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;
  logic             mode_change, src_tick, step, hit;
  logic             old_b, new_b;
  logic [IDX_W-1:0] watch_idx;
  src_sel_e         src_sel;

  assign src_sel     = src_sel_e'(mode_q[7:5]);
  assign mode_change = mode_we_i && (mode_wdata_i != mode_q);

  tick_mux #(.SYNC_STAGES(SYNC_STAGES)) mux_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_sys_i  (tick_sys_i),
    .tick_hrc_i  (tick_hrc_i),
    .tick_xosc_i (tick_xosc_i),
    .tick_lrc_i  (tick_lrc_i),
    .pin_a_i     (pin_a_i),
    .pin_b_i     (pin_b_i),
    .sel_i       (src_sel),
    .tick_o      (src_tick)
  );

  prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (src_tick),
    .clr_i       (mode_change),
    .ratio_sel_i (mode_q[4:3]),
    .carry_o     (step)
  );

  assign cnt_inc   = cnt_q + 1'b1;
  assign watch_idx = IDX_W'(SEL_BASE) + IDX_W'(mode_q[2:0]);
  assign old_b     = cnt_q[watch_idx];
  assign new_b     = cnt_inc[watch_idx];
  // loads never raise a request
  assign hit = step && !cnt_we_i && (old_b != new_b) &&
               (edge_q[EDGE_BIT] ? !new_b : new_b);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we_i)  cnt_d = cnt_wdata_i;
    else if (step) cnt_d = cnt_inc;
  end

  always_comb begin
    irq_d = irq_we_i ? irq_wdata_i : irq_q;
    if (hit) irq_d[IRQ_BIT] = 1'b1;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      edge_q <= '0;
      cnt_q  <= '0;
      irq_q  <= '0;
    end else begin
      if (mode_change) mode_q <= mode_wdata_i;
      if (edge_we_i)   edge_q <= edge_wdata_i;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign mode_o = mode_q;
  assign edge_o = edge_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  a_r9_hold_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_sel == SRC_OFF0 || src_sel == SRC_OFF2) && !cnt_we_i) |=> $stable(cnt_q));
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q[IRQ_BIT] && !(irq_we_i && !irq_wdata_i[IRQ_BIT])) |=> irq_q[IRQ_BIT]);
  a_r8_same_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_wdata_i == mode_q) |=> $stable(mode_q));
  a_r4_no_flag_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !irq_we_i && !irq_q[IRQ_BIT]) |=> !irq_q[IRQ_BIT]);
endmodule

// File: tb/prescale_toggle_timer_tb_top.sv
module prescale_toggle_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_sys_i = 0, tick_hrc_i = 0, tick_xosc_i = 0, tick_lrc_i = 0;
  logic        pin_a_i = 0, pin_b_i = 0;
  logic        mode_we_i = 0, edge_we_i = 0, cnt_we_i = 0, irq_we_i = 0;
  logic [7:0]  mode_wdata_i = '0, edge_wdata_i = '0, irq_wdata_i = '0;
  logic [15:0] cnt_wdata_i = '0;
  logic [7:0]  mode_o, edge_o, irq_o;
  logic [15:0] cnt_o;

  int n_chk = 0, n_err = 0;
  string       tag_q[$];
  logic [31:0] exp_q[$];
  logic [7:0]  cur_mode = '0;
  bit          done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  prescale_toggle_timer dut_i (
    .clk_i, .rst_ni, .tick_sys_i, .tick_hrc_i, .tick_xosc_i, .tick_lrc_i,
    .pin_a_i, .pin_b_i, .mode_we_i, .mode_wdata_i, .edge_we_i, .edge_wdata_i,
    .cnt_we_i, .cnt_wdata_i, .irq_we_i, .irq_wdata_i,
    .mode_o, .edge_o, .cnt_o, .irq_o
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_now(string tag, logic [15:0] c, logic [7:0] irq);
    tag_q.push_back(tag);
    exp_q.push_back({cur_mode, irq, c});
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    #1;
    while (exp_q.size() > 0) begin
      logic [31:0] e;
      logic [31:0] act;
      string t;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      act = {mode_o, irq_o, cnt_o};
      n_chk++;
      if (act !== e) begin
        n_err++;
        $display("FAIL %s: actual cnt=%h irq=%h mode=%h expected cnt=%h irq=%h mode=%h",
                 t, act[15:0], act[23:16], act[31:24], e[15:0], e[23:16], e[31:24]);
      end
    end
  end

  // which: 0 sys, 1 fast rc, 2 crystal, 3 slow rc, 4 all
  task automatic ticks(int which, int n);
    if (n == 0) return;
    tick_sys_i  = (which == 0 || which == 4);
    tick_hrc_i  = (which == 1 || which == 4);
    tick_xosc_i = (which == 2 || which == 4);
    tick_lrc_i  = (which == 3 || which == 4);
    cyc(n);
    {tick_sys_i, tick_hrc_i, tick_xosc_i, tick_lrc_i} = '0;
  endtask

  task automatic wr_mode(logic [7:0] v);
    mode_we_i = 1; mode_wdata_i = v; cyc(1); mode_we_i = 0;
    cur_mode = v;
  endtask
  task automatic wr_edge(logic [7:0] v);
    edge_we_i = 1; edge_wdata_i = v; cyc(1); edge_we_i = 0;
  endtask
  task automatic wr_cnt(logic [15:0] v);
    cnt_we_i = 1; cnt_wdata_i = v; cyc(1); cnt_we_i = 0;
  endtask
  task automatic wr_irq(logic [7:0] v);
    irq_we_i = 1; irq_wdata_i = v; cyc(1); irq_we_i = 0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    expect_now("R1 reset state", 16'h0000, 8'h00);
    if (edge_o !== 8'h00) begin
      n_err++; $display("FAIL R1 edge reg: actual %h expected 00", edge_o);
    end
    n_chk++;
    ticks(4, 5);
    expect_now("R1 R9 no source after reset", 16'h0000, 8'h00);

    // R2 source selection
    wr_mode(8'h20);
    ticks(0, 5);
    expect_now("R2 system tick div1", 16'd5, 8'h00);
    ticks(1, 4); ticks(2, 4); ticks(3, 4);
    expect_now("R2 unselected sources ignored", 16'd5, 8'h00);
    wr_mode(8'h80);
    ticks(0, 3);
    ticks(1, 3);
    expect_now("R2 fast rc selected", 16'd8, 8'h00);
    wr_mode(8'hA0);
    ticks(2, 2);
    expect_now("R2 crystal selected", 16'd10, 8'h00);
    wr_mode(8'hC0);
    ticks(3, 2);
    expect_now("R2 slow rc selected", 16'd12, 8'h00);
    wr_mode(8'h40);
    ticks(4, 6);
    expect_now("R2 R9 code 2 holds", 16'd12, 8'h00);

    // R3 prescale ratios
    wr_cnt(16'h0000);
    wr_mode(8'h28);
    ticks(0, 7);
    expect_now("R3 div4 seven ticks", 16'd1, 8'h00);
    wr_mode(8'h30);
    ticks(0, 15);
    expect_now("R3 div16 fifteen ticks", 16'd1, 8'h00);
    ticks(0, 1);
    expect_now("R3 div16 sixteenth tick", 16'd2, 8'h00);
    wr_mode(8'h38);
    ticks(0, 63);
    expect_now("R3 div64 63 ticks", 16'd2, 8'h00);
    ticks(0, 1);
    expect_now("R3 div64 64th tick", 16'd3, 8'h00);

    // R9 none holds the prescaler
    wr_mode(8'h28);
    ticks(0, 3);
    wr_mode(8'h08);
    ticks(0, 5);
    expect_now("R9 none holds counter", 16'd3, 8'h00);
    wr_mode(8'h28);  // different value, clears prescaler
    ticks(0, 3);
    expect_now("R8 clear after change", 16'd3, 8'h00);
    ticks(0, 1);
    expect_now("R8 count after change", 16'd4, 8'h00);

    // R8 different vs same value writes
    ticks(0, 3);
    wr_mode(8'h29);
    ticks(0, 3);
    expect_now("R8 differing write cleared prescaler", 16'd4, 8'h00);
    ticks(0, 1);
    expect_now("R8 full ratio after clear", 16'd5, 8'h00);
    ticks(0, 3);
    wr_mode(8'h29);
    ticks(0, 1);
    expect_now("R8 same write keeps prescaler", 16'd6, 8'h00);

    // R4 wrap, load priority, no flag on load
    wr_mode(8'h20);
    wr_cnt(16'hFFFF);
    ticks(0, 1);
    expect_now("R4 wrap to zero", 16'h0000, 8'h00);
    tick_sys_i = 1; cnt_we_i = 1; cnt_wdata_i = 16'h1234;
    cyc(1);
    tick_sys_i = 0; cnt_we_i = 0;
    expect_now("R4 load beats increment", 16'h1234, 8'h00);
    wr_cnt(16'h00FF);
    wr_cnt(16'h0100);
    expect_now("R4 load crossing watched bit no flag", 16'h0100, 8'h00);

    // R6 rising on bit 8
    wr_cnt(16'h00FF);
    ticks(0, 1);
    expect_now("R6 rising edge bit8 flags", 16'h0100, 8'h04);
    wr_irq(8'h00);
    wr_cnt(16'h01FF);
    ticks(0, 1);
    expect_now("R6 falling ignored when rising selected", 16'h0200, 8'h00);
    // R6 falling
    wr_edge(8'h10);
    wr_cnt(16'h01FF);
    ticks(0, 1);
    expect_now("R6 falling edge flags", 16'h0200, 8'h04);
    wr_irq(8'h00);
    wr_cnt(16'h00FF);
    ticks(0, 1);
    expect_now("R6 rising ignored when falling selected", 16'h0100, 8'h00);
    wr_edge(8'h00);

    // R5 watched bit 11
    wr_mode(8'h23);
    wr_cnt(16'h00FF);
    ticks(0, 1);
    expect_now("R5 bit8 change ignored when bit11 watched", 16'h0100, 8'h00);
    wr_cnt(16'h07FF);
    ticks(0, 1);
    expect_now("R5 bit11 rising flags", 16'h0800, 8'h04);
    wr_mode(8'h27);
    wr_cnt(16'h7FFF);
    wr_irq(8'h00);
    ticks(0, 1);
    expect_now("R5 bit15 rising flags", 16'h8000, 8'h04);

    // R7 other bits kept, set wins
    wr_mode(8'h20);
    wr_irq(8'hA1);
    expect_now("R7 software write", 16'h8000, 8'hA1);
    wr_cnt(16'h00FF);
    ticks(0, 1);
    expect_now("R7 set keeps other bits", 16'h0100, 8'hA5);
    wr_cnt(16'h00FF);
    tick_sys_i = 1; irq_we_i = 1; irq_wdata_i = 8'h00;
    cyc(1);
    tick_sys_i = 0; irq_we_i = 0;
    expect_now("R7 set wins over clear", 16'h0100, 8'h04);
    wr_irq(8'h00);
    expect_now("R7 software clear", 16'h0100, 8'h00);

    // R10 pins
    wr_mode(8'h60);
    wr_cnt(16'h0000);
    pin_a_i = 1;
    cyc(2);
    expect_now("R10 pin not yet through sync", 16'd0, 8'h00);
    cyc(1);
    expect_now("R10 pin edge counted after sync", 16'd1, 8'h00);
    cyc(3);
    expect_now("R10 steady level adds nothing", 16'd1, 8'h00);
    pin_a_i = 0; cyc(3);
    pin_a_i = 1; cyc(3);
    expect_now("R10 second rising edge", 16'd2, 8'h00);
    wr_mode(8'hE0);
    pin_a_i = 0; cyc(3);
    pin_a_i = 1; cyc(4);
    expect_now("R10 R2 pin A ignored on pin B source", 16'd2, 8'h00);
    pin_b_i = 1; cyc(3);
    expect_now("R10 pin B edge counted", 16'd3, 8'h00);

    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule